// File: doc/BRIEF.md
# ADC Event Interrupt Controller

This block gathers five event lines from an analog-to-digital converter and reduces them to one interrupt request. Each source can be detected on its level or on its edges. The choice of level or edge is made per source, independently of which polarity is selected. Two separate polarity masks pick the response. One mask selects the high level or the rising edge. The other selects the low level or the falling edge. Setting both on an edge-mode source makes it fire on either transition.

Software sees a byte-wide register port. Writes are strobed and reads are combinational. The enable mask is never written directly. One address turns on the bits written as 1 and another address turns off the bits written as 1, so two agents can change different sources without a read-modify-write. An edge that is detected while its source is enabled is held as pending. It stays pending until that source's enable is cleared. A level event is not held and follows the sampled input. The event lines are registered once before detection.

The unit has no sequencing of its own. It is a set of per-source detectors beside a register file, so no state machine is involved.

Top module: `adc_irq_ctrl`

## Requirements
- R1: After reset the type, high-polarity, low-polarity and enable registers all read 0, and `irq_out` is low.
- R2: The register offsets are fixed: type at 0x11, high polarity at 0x12, low polarity at 0x13. Reading any of these returns the low five bits last written, and bits 7..5 always read 0.
- R3: Offset 0x10 returns the event inputs as sampled at the most recent clock edge, with source n at bit n. This register is read-only, and writes to it have no effect.
- R4: Writing to offset 0x15 enables every source whose data bit is 1. Sources written with 0 keep their current enable.
- R5: Writing to offset 0x16 disables every source whose data bit is 1. Reading either 0x15 or 0x16 returns the current enable mask.
- R6: A type bit of 0 selects level mode. In level mode an enabled source with its high-polarity bit set drives `irq_out` while its sampled input is 1. One with its low-polarity bit set drives it while the sampled input is 0. `irq_out` changes after the first clock edge that samples a new input value.
- R7: A type bit of 1 selects edge mode. The high-polarity bit catches 0-to-1 transitions and the low-polarity bit catches 1-to-0 transitions, and setting both catches either. `irq_out` rises after the second clock edge following the input change.
- R8: A caught edge stays pending, holding `irq_out` high after the input returns. It is removed only by a 1 written to that source's bit at 0x16. Pending state of other sources is unaffected.
- R9: An edge that occurs while its source is disabled is not recorded, so a later enable raises no interrupt.
- R10: `irq_out` is the OR over all sources of (enabled AND active). The bit assignment is: 0 end of conversion, 1 FIFO not empty, 2 sequence timeout, 3 high threshold, 4 low threshold.
- R11: Any offset outside the map reads 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| evt_raw | input | 5 | Raw event lines, bit n is source n |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The bench checks the edge latency by confirming that `irq_out` is still low one edge after a transition. A design that left out the sampling stage, or that compared against the wrong previous value, would assert one cycle early or would never assert. It checks that a pending edge survives the input returning to idle and that clearing one source leaves another source's pending bit in place. A design that cleared pending state globally, or that tied pending to the input level, would drop the interrupt early. It also pulses an input while the source is disabled and then enables it, to catch a detector that latches regardless of enable. Finally it drives a rising edge into a falling-only source and drives both edges into a dual-polarity source, which exposes a polarity decode that is swapped or merged.

// File: rtl/adc_irq_pkg.sv
package adc_irq_pkg;

    // register offsets; software decodes these
    localparam int ADR_STATUS = 'h10;
    localparam int ADR_TYPE   = 'h11;
    localparam int ADR_POL_HI = 'h12;
    localparam int ADR_POL_LO = 'h13;
    localparam int ADR_EN_SET = 'h15;
    localparam int ADR_EN_CLR = 'h16;

    // source bit positions
    typedef enum int {
        SRC_EOC      = 0,
        SRC_FIFO     = 1,
        SRC_SEQ_TMO  = 2,
        SRC_THR_HIGH = 3,
        SRC_THR_LOW  = 4
    } src_idx_e;

endpackage

// File: rtl/adc_irq_src.sv
module adc_irq_src (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic edge_i,
    input  logic hi_i,
    input  logic lo_i,
    input  logic en_i,
    input  logic clr_i,
    output logic lvl_o,
    output logic fire_o
);
    logic smp_now, smp_prev, pend_q;
    logic rise, fall, edge_hit, lvl_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_now  <= 1'b0;
            smp_prev <= 1'b0;
        end else begin
            smp_now  <= evt_i;
            smp_prev <= smp_now;
        end
    end

    assign rise     = smp_now & ~smp_prev;
    assign fall     = ~smp_now & smp_prev;
    assign edge_hit = edge_i & ((hi_i & rise) | (lo_i & fall));
    assign lvl_hit  = (hi_i & smp_now) | (lo_i & ~smp_now);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (clr_i)
            pend_q <= 1'b0;
        else if (edge_hit && en_i)
            pend_q <= 1'b1;
    end

    assign lvl_o  = smp_now;
    assign fire_o = en_i & (edge_i ? pend_q : lvl_hit);

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !clr_i) |=> pend_q);  // R8

    AST_PEND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !pend_q);  // R8

    AST_PEND_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> $past(en_i));  // R9

endmodule

// File: rtl/adc_irq_regs.sv
module adc_irq_regs
    import adc_irq_pkg::*;
#(
    parameter int NUM_SRC = 5,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    input  logic [NUM_SRC-1:0] lvl_i,
    output logic [NUM_SRC-1:0] type_o,
    output logic [NUM_SRC-1:0] pol_hi_o,
    output logic [NUM_SRC-1:0] pol_lo_o,
    output logic [NUM_SRC-1:0] en_o,
    output logic [NUM_SRC-1:0] clr_o
);
    logic [NUM_SRC-1:0] type_q, hi_q, lo_q, en_q;
    logic [NUM_SRC-1:0] wbits;
    logic hit_type, hit_hi, hit_lo, hit_set, hit_clr;

    assign wbits    = wdata[NUM_SRC-1:0];
    assign hit_type = wr_en && (addr == ADDR_W'(ADR_TYPE));
    assign hit_hi   = wr_en && (addr == ADDR_W'(ADR_POL_HI));
    assign hit_lo   = wr_en && (addr == ADDR_W'(ADR_POL_LO));
    assign hit_set  = wr_en && (addr == ADDR_W'(ADR_EN_SET));
    assign hit_clr  = wr_en && (addr == ADDR_W'(ADR_EN_CLR));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            type_q <= '0;
            hi_q   <= '0;
            lo_q   <= '0;
            en_q   <= '0;
        end else begin
            if (hit_type) type_q <= wbits;
            if (hit_hi)   hi_q   <= wbits;
            if (hit_lo)   lo_q   <= wbits;
            if (hit_set)       en_q <= en_q | wbits;
            else if (hit_clr)  en_q <= en_q & ~wbits;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(ADR_STATUS): rdata[NUM_SRC-1:0] = lvl_i;
            ADDR_W'(ADR_TYPE):   rdata[NUM_SRC-1:0] = type_q;
            ADDR_W'(ADR_POL_HI): rdata[NUM_SRC-1:0] = hi_q;
            ADDR_W'(ADR_POL_LO): rdata[NUM_SRC-1:0] = lo_q;
            ADDR_W'(ADR_EN_SET),
            ADDR_W'(ADR_EN_CLR): rdata[NUM_SRC-1:0] = en_q;
            default:             rdata = '0;
        endcase
    end

    assign type_o   = type_q;
    assign pol_hi_o = hi_q;
    assign pol_lo_o = lo_q;
    assign en_o     = en_q;
    assign clr_o    = hit_clr ? wbits : '0;

    AST_EN_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        hit_set |=> ((en_q & $past(wbits)) == $past(wbits)));  // R4

    AST_EN_SET_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        hit_set |=> ((en_q & ~$past(wbits)) == ($past(en_q) & ~$past(wbits))));  // R4

    AST_EN_CLR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        hit_clr |=> ((en_q & $past(wbits)) == '0));  // R5

endmodule

// File: rtl/adc_irq_ctrl.sv
module adc_irq_ctrl
    import adc_irq_pkg::*;
#(
    parameter int NUM_SRC = 5,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic [NUM_SRC-1:0] evt_raw,
    output logic               irq_out
);
    logic [NUM_SRC-1:0] type_v, hi_v, lo_v, en_v, clr_v, lvl_v, fire_v;

    adc_irq_regs #(
        .NUM_SRC(NUM_SRC),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_we),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .lvl_i   (lvl_v),
        .type_o  (type_v),
        .pol_hi_o(hi_v),
        .pol_lo_o(lo_v),
        .en_o    (en_v),
        .clr_o   (clr_v)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        adc_irq_src u_src (
            .clk   (clk),
            .rst_n (rst_n),
            .evt_i (evt_raw[g]),
            .edge_i(type_v[g]),
            .hi_i  (hi_v[g]),
            .lo_i  (lo_v[g]),
            .en_i  (en_v[g]),
            .clr_i (clr_v[g]),
            .lvl_o (lvl_v[g]),
            .fire_o(fire_v[g])
        );
    end

    assign irq_out = |fire_v;

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (en_v != '0));  // R10

    AST_STATUS_SAMPLED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(ADR_STATUS)) |=>
            (reg_rdata[NUM_SRC-1:0] == $past(evt_raw)) ||
            (reg_addr != ADDR_W'(ADR_STATUS)));  // R3

endmodule

// File: tb/adc_irq_ctrl_bench.sv
module adc_irq_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       we = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [4:0] evt = 5'b0;
    logic       irq;
    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    adc_irq_ctrl u_adc_irq_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_we   (we),
        .reg_addr (addr),
        .reg_wdata(wdata),
        .reg_rdata(rdata),
        .evt_raw  (evt),
        .irq_out  (irq)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string tag);
        addr = a;
        #1;
        chk(rdata, exp, tag);
    endtask

    task automatic irq_chk(input logic exp, input string tag);
        chk({7'b0, irq}, {7'b0, exp}, tag);
    endtask

    task automatic t_reset();
        rd_chk(8'h11, 8'h00, "R1 type");
        rd_chk(8'h12, 8'h00, "R1 pol_hi");
        rd_chk(8'h13, 8'h00, "R1 pol_lo");
        rd_chk(8'h15, 8'h00, "R1 enable");
        irq_chk(1'b0, "R1 irq");
    endtask

    task automatic t_regmap();
        wr(8'h11, 8'hFF); rd_chk(8'h11, 8'h1F, "R2 type mask");
        wr(8'h12, 8'hA5); rd_chk(8'h12, 8'h05, "R2 pol_hi");
        wr(8'h13, 8'h6A); rd_chk(8'h13, 8'h0A, "R2 pol_lo");
        wr(8'h11, 8'h00); wr(8'h12, 8'h00); wr(8'h13, 8'h00);
        wr(8'h14, 8'hFF);
        rd_chk(8'h14, 8'h00, "R11 unmapped read");
        rd_chk(8'h15, 8'h00, "R11 unmapped write no enable");
        rd_chk(8'h11, 8'h00, "R11 unmapped write no type");
        wr(8'h10, 8'hFF);
        rd_chk(8'h10, 8'h00, "R3 status write ignored");
        rd_chk(8'h12, 8'h00, "R3 status write no pol");
    endtask

    task automatic t_status();
        evt = 5'b10110;
        tick(1);
        rd_chk(8'h10, 8'h16, "R3 status sample");
        evt = 5'b00001;
        rd_chk(8'h10, 8'h16, "R3 status before edge");
        tick(1);
        rd_chk(8'h10, 8'h01, "R3 status update");
        evt = 5'b0;
        tick(2);
    endtask

    task automatic t_enable();
        wr(8'h15, 8'h05); rd_chk(8'h15, 8'h05, "R4 set");
        wr(8'h15, 8'h02); rd_chk(8'h15, 8'h07, "R4 set keeps others");
        wr(8'h16, 8'h04); rd_chk(8'h16, 8'h03, "R5 clear");
        rd_chk(8'h15, 8'h03, "R5 read via set offset");
        wr(8'h16, 8'hFF); rd_chk(8'h15, 8'h00, "R5 clear all");
    endtask

    task automatic t_level();
        wr(8'h12, 8'h01); wr(8'h15, 8'h01);
        irq_chk(1'b0, "R6 low input no irq");
        evt[0] = 1'b1; tick(1);
        irq_chk(1'b1, "R6 high level fires");
        evt[0] = 1'b0; tick(1);
        irq_chk(1'b0, "R6 level follows input");
        wr(8'h16, 8'h01); wr(8'h12, 8'h00);
        wr(8'h13, 8'h02); wr(8'h15, 8'h02);
        irq_chk(1'b1, "R6 low level fires");
        evt[1] = 1'b1; tick(1);
        irq_chk(1'b0, "R6 low level released");
        evt[1] = 1'b0;
        wr(8'h16, 8'h1F); wr(8'h13, 8'h00);
    endtask

    task automatic t_edge();
        wr(8'h11, 8'h1F); wr(8'h12, 8'h11); wr(8'h13, 8'h18);
        wr(8'h15, 8'h19);
        irq_chk(1'b0, "R7 idle");
        evt[0] = 1'b1; tick(1);
        irq_chk(1'b0, "R7 latency one edge");
        tick(1);
        irq_chk(1'b1, "R7 rising caught");
        evt[0] = 1'b0; tick(3);
        irq_chk(1'b1, "R8 pending sticky");
        wr(8'h16, 8'h01);
        irq_chk(1'b0, "R8 clear removes pending");
        wr(8'h15, 8'h01);
        irq_chk(1'b0, "R8 reenable no stale pending");
        evt[3] = 1'b1; tick(3);
        irq_chk(1'b0, "R7 falling-only ignores rise");
        evt[3] = 1'b0; tick(2);
        irq_chk(1'b1, "R7 falling caught");
        wr(8'h16, 8'h08); wr(8'h15, 8'h08);
        irq_chk(1'b0, "R8 bit3 cleared");
        evt[4] = 1'b1; tick(2);
        irq_chk(1'b1, "R7 both-edge rise");
        wr(8'h16, 8'h10); wr(8'h15, 8'h10);
        irq_chk(1'b0, "R8 bit4 cleared");
        evt[4] = 1'b0; tick(2);
        irq_chk(1'b1, "R7 both-edge fall");
        wr(8'h16, 8'h10);
        irq_chk(1'b0, "R8 bit4 cleared again");
    endtask

    task automatic t_disabled();
        wr(8'h16, 8'h01);
        evt[0] = 1'b1; tick(2);
        evt[0] = 1'b0; tick(2);
        wr(8'h15, 8'h01);
        tick(1);
        irq_chk(1'b0, "R9 disabled edge dropped");
    endtask

    task automatic t_or();
        // enabled now: bit0 (EOC rising) and bit3 (high threshold falling)
        evt[0] = 1'b1; evt[3] = 1'b1; tick(2);
        evt[0] = 1'b0; evt[3] = 1'b0; tick(2);
        irq_chk(1'b1, "R10 two pending");
        wr(8'h16, 8'h01);
        irq_chk(1'b1, "R10 other source holds irq");
        wr(8'h16, 8'h08);
        irq_chk(1'b0, "R10 all cleared");
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_regmap();
        t_status();
        t_enable();
        t_level();
        t_edge();
        t_disabled();
        t_or();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule